// File: doc/BRIEF.md
# Sleep-Mode Interrupt Capture Controller

This block watches a bank of peripheral interrupt lines while the main interrupt distributor is powered down. Each line that fires while capture is armed is held as a pending bit, so that software can later read the pending status and replay those interrupts to the distributor once it is back up. A combined wake-up output goes high whenever an unmasked line is pending. It can be used to bring the system out of its low-power state.

Every line carries four attributes: a mask bit, a sensitivity (edge or level), a polarity (active-high or active-low) and a pending bit. Software reaches them through a 32-bit register bus with separate write and read strobes and a word address. The address splits into a window number in the upper five bits and a word-within-window index in the lower three bits. Mask, sensitivity and polarity each have a read window, a set window and a clear window. The set and clear windows act only on bits written as 1. An acknowledge window clears pending bits. A status window returns them. A control word holds an enable bit, a global edge-only mode bit and a self-clearing soft-reset bit. The number of lines is a parameter.

Top module: `wake_irq_capture`

## Requirements
- R1: Line n is bit (n mod 32) of the word whose index is n/32 within a window, and the window number is address bits [7:3]. The windows are numbered as follows: 0 control, 1 mask read, 2 mask set, 3 mask clear, 4 sensitivity read, 5 sensitivity set, 6 sensitivity clear, 7 polarity read, 8 polarity set, 9 polarity clear, 10 acknowledge, 11 status.
- R2: Writing 1 to a bit of a set or clear window sets or clears only that line's attribute. Bits written as 0 leave their lines unchanged.
- R3: Encodings are as follows: mask 1 means masked, sensitivity 1 means level and 0 means edge, polarity 1 means active-high and 0 means active-low. After reset all lines are masked, edge-sensitive and active-high, nothing is pending, and the control word is 0.
- R4: Writing 1 to a bit of the acknowledge window clears that line's pending bit. Writing all 1s clears every line of that word.
- R5: The status window returns the pending bits. A read returns its data on rd_data one cycle after rd_en.
- R6: Capture happens only while control bit 0 (enable) is 1. An edge line becomes pending on a rising edge of its effective input, which is the synchronized line XOR the inverted polarity bit. The pending bit is visible three clock edges after the raw line changes.
- R7: A level line is pending while its effective input is high. An acknowledge clears it for one cycle, and it re-latches on the next cycle if the input is still active.
- R8: While control bit 1 (edge-only) is 1, every line is treated as edge-sensitive, whatever its sensitivity bit.
- R9: On an armed edge line with a static input, setting its polarity negative, then positive, then negative again makes the line pending.
- R10: The wake output is high exactly when some pending line is unmasked. Masked lines still latch pending status.
- R11: Writing 1 to control bit 2 (soft reset) clears all pending bits, masks every line and clears enable one cycle later, then the bit clears itself. Sensitivity, polarity and edge-only keep their values.
- R12: Reads of the set, clear and acknowledge windows, of unused window numbers and of word indices beyond the line count return 0. Control bit 0 can be cleared without changing edge-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Raw asynchronous interrupt lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write word address (window, word) |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Read word address (window, word) |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| wake | output | 1 | High while any unmasked line is pending |

## Verification
Every cycle the checker confirms four things. Pending bits never appear while capture is disarmed. Acknowledged bits are clear on the following cycle. The soft-reset bit clears itself and leaves pending, enable and mask in their reset state. Wake is only high with something pending. The directed scenarios are needed for the rest: the window address map and the write-one semantics, the three-edge capture latency, level re-latching after an acknowledge, the edge-only override, the polarity-flip capture, the upper-word lines and zero reads from unimplemented addresses.

// File: rtl/wic_pkg.sv
package wic_pkg;
    localparam int BUS_W     = 32;
    localparam int WIN_W     = 5;
    localparam int WSEL_W    = 3;
    localparam int ADDR_W    = WIN_W + WSEL_W;
    localparam int MAX_WORDS = 1 << WSEL_W;

    typedef enum logic [WIN_W-1:0] {
        W_CTRL     = 5'd0,
        W_MASK_RD  = 5'd1,
        W_MASK_SET = 5'd2,
        W_MASK_CLR = 5'd3,
        W_SENS_RD  = 5'd4,
        W_SENS_SET = 5'd5,
        W_SENS_CLR = 5'd6,
        W_POL_RD   = 5'd7,
        W_POL_SET  = 5'd8,
        W_POL_CLR  = 5'd9,
        W_ACK      = 5'd10,
        W_STAT     = 5'd11
    } win_e;

    typedef struct packed {
        logic srst;
        logic edge_only;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        win_e              win;
        logic [WSEL_W-1:0] word;
    } addr_t;

    function automatic int words_for(int lines);
        return (lines + BUS_W - 1) / BUS_W;
    endfunction
endpackage

// File: rtl/wic_sync.sv
module wic_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/wic_regs.sv
module wic_regs
    import wic_pkg::*;
#(
    parameter int N = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    output ctrl_t             ctrl,
    output logic [N-1:0]      mask,
    output logic [N-1:0]      sens,
    output logic [N-1:0]      pol,
    output logic [N-1:0]      ack
);
    localparam int WORDS = words_for(N);
    localparam int PADW  = WORDS * BUS_W;

    addr_t           wa;
    logic [PADW-1:0] spread;
    logic [N-1:0]    bits;

    assign wa = wr_addr;

    always_comb begin
        spread = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (int'(wa.word) == w) spread[w*BUS_W +: BUS_W] = wr_data;
        end
    end
    assign bits = spread[N-1:0];

    function automatic logic hit(win_e x);
        return wr_en && (wa.win == x);
    endfunction

    assign ack = hit(W_ACK) ? bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            mask <= '1;
            sens <= '0;
            pol  <= '1;
        end else begin
            if (ctrl.srst) begin
                ctrl.srst   <= 1'b0;
                ctrl.enable <= 1'b0;
                mask        <= '1;
            end else begin
                if (hit(W_CTRL))     ctrl <= ctrl_t'(wr_data[2:0]);
                if (hit(W_MASK_SET)) mask <= mask | bits;
                if (hit(W_MASK_CLR)) mask <= mask & ~bits;
            end
            if (hit(W_SENS_SET)) sens <= sens | bits;
            if (hit(W_SENS_CLR)) sens <= sens & ~bits;
            if (hit(W_POL_SET))  pol  <= pol | bits;
            if (hit(W_POL_CLR))  pol  <= pol & ~bits;
        end
    end
endmodule

// File: rtl/wic_capture.sv
module wic_capture #(
    parameter int N = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] line,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] sens,
    input  logic         edge_only,
    input  logic         enable,
    input  logic [N-1:0] ack,
    input  logic         srst,
    output logic [N-1:0] pending
);
    logic [N-1:0] eff, prev, rise, lvl, fire;

    assign eff  = line ^ ~pol;
    assign rise = eff & ~prev;
    assign lvl  = sens & ~{N{edge_only}};
    assign fire = (lvl & eff) | (~lvl & rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev    <= '0;
            pending <= '0;
        end else begin
            prev <= eff;
            if (srst) pending <= '0;
            else      pending <= (pending | (enable ? fire : '0)) & ~ack;
        end
    end
endmodule

// File: rtl/wake_irq_capture.sv
module wake_irq_capture
    import wic_pkg::*;
#(
    parameter int NUM_LINES = 40
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 wr_en,
    input  logic [7:0]           wr_addr,
    input  logic [31:0]          wr_data,
    input  logic                 rd_en,
    input  logic [7:0]           rd_addr,
    output logic [31:0]          rd_data,
    output logic                 wake
);
    localparam int WORDS = words_for(NUM_LINES);
    localparam int PADW  = WORDS * BUS_W;

    ctrl_t                ctrl_q;
    logic [NUM_LINES-1:0] mask_q, sens_q, pol_q, ack_vec, line_s, pending;
    logic [PADW-1:0]      mask_p, sens_p, pol_p, pend_p;
    addr_t                ra;
    logic [BUS_W-1:0]     rd_word;

    wic_sync #(.W(NUM_LINES)) u_sync (
        .clk(clk), .rst(rst), .d(irq_in), .q(line_s)
    );

    wic_regs #(.N(NUM_LINES)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl(ctrl_q), .mask(mask_q), .sens(sens_q),
        .pol(pol_q), .ack(ack_vec)
    );

    wic_capture #(.N(NUM_LINES)) u_cap (
        .clk(clk), .rst(rst), .line(line_s), .pol(pol_q), .sens(sens_q),
        .edge_only(ctrl_q.edge_only), .enable(ctrl_q.enable), .ack(ack_vec),
        .srst(ctrl_q.srst), .pending(pending)
    );

    assign wake = |(pending & ~mask_q);

    assign mask_p = PADW'(mask_q);
    assign sens_p = PADW'(sens_q);
    assign pol_p  = PADW'(pol_q);
    assign pend_p = PADW'(pending);
    assign ra     = rd_addr;

    function automatic logic [BUS_W-1:0] pick(logic [PADW-1:0] v, logic [WSEL_W-1:0] w);
        logic [BUS_W-1:0] r;
        r = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (int'(w) == i) r = v[i*BUS_W +: BUS_W];
        end
        return r;
    endfunction

    always_comb begin
        rd_word = '0;
        case (ra.win)
            W_CTRL:    if (ra.word == '0) rd_word = {{(BUS_W-3){1'b0}}, ctrl_q};
            W_MASK_RD: rd_word = pick(mask_p, ra.word);
            W_SENS_RD: rd_word = pick(sens_p, ra.word);
            W_POL_RD:  rd_word = pick(pol_p, ra.word);
            W_STAT:    rd_word = pick(pend_p, ra.word);
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_word;
    end
endmodule

// File: rtl/wic_checker.sv
module wic_checker #(
    parameter int N = 40
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] pending,
    input logic [N-1:0] mask,
    input logic [N-1:0] ack,
    input logic         srst,
    input logic         enable,
    input logic         wake
);
    a_r6_no_capture_disarmed: assert property (@(posedge clk) disable iff (rst)
        !enable |=> ((pending & ~$past(pending)) == '0));

    a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack != '0) |=> ((pending & $past(ack)) == '0));

    a_r11_srst_self_clears: assert property (@(posedge clk) disable iff (rst)
        srst |=> !srst);

    a_r11_srst_effect: assert property (@(posedge clk) disable iff (rst)
        srst |=> (pending == '0 && !enable && mask == '1));

    a_r10_wake_has_source: assert property (@(posedge clk) disable iff (rst)
        wake |-> (pending != '0));
endmodule

bind wake_irq_capture wic_checker #(.N(NUM_LINES)) u_chk (
    .clk(clk), .rst(rst), .pending(pending), .mask(mask_q), .ack(ack_vec),
    .srst(ctrl_q.srst), .enable(ctrl_q.enable), .wake(wake)
);

// File: tb/wake_irq_capture_tb.sv
module wake_irq_capture_tb;
    localparam int N = 40;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  irq_in;
    logic          wr_en, rd_en;
    logic [7:0]    wr_addr, rd_addr;
    logic [31:0]   wr_data, rd_data;
    logic          wake;
    int            checks = 0;
    int            fails  = 0;
    bit            done   = 1'b0;

    always #2 clk = ~clk;

    wake_irq_capture #(.NUM_LINES(N)) u_dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wake(wake)
    );

    // window addresses: window number * 8 + word
    localparam logic [7:0] A_CTRL = 8'd0,  A_MASK = 8'd8,  A_MSET = 8'd16, A_MCLR = 8'd24;
    localparam logic [7:0] A_SENS = 8'd32, A_SSET = 8'd40, A_SCLR = 8'd48;
    localparam logic [7:0] A_POL  = 8'd56, A_PSET = 8'd64, A_PCLR = 8'd72;
    localparam logic [7:0] A_ACK  = 8'd80, A_STAT = 8'd88;

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rd_data, exp);
    endtask

    task automatic pulse(int n);
        @(negedge clk); irq_in[n] = 1'b1;
        repeat (4) @(negedge clk);
        irq_in[n] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        rd_chk("R3 ctrl reset", A_CTRL, 32'h0);
        rd_chk("R3 mask w0 reset", A_MASK, 32'hFFFF_FFFF);
        rd_chk("R1 mask w1 reset", A_MASK + 8'd1, 32'h0000_00FF);
        rd_chk("R3 sens reset", A_SENS, 32'h0);
        rd_chk("R3 pol reset", A_POL, 32'hFFFF_FFFF);
        rd_chk("R5 stat reset", A_STAT, 32'h0);
        check("R10 wake reset", 32'(wake), 32'h0);
    endtask

    task automatic t_windows;
        wr(A_MCLR, 32'h0000_000E);
        rd_chk("R2 mask clear", A_MASK, 32'hFFFF_FFF1);
        wr(A_MSET, 32'h0);
        rd_chk("R2 zero write no effect", A_MASK, 32'hFFFF_FFF1);
        wr(A_MSET, 32'h2);
        rd_chk("R2 mask set", A_MASK, 32'hFFFF_FFF3);
        wr(A_MCLR, 32'h2);
    endtask

    task automatic t_disabled;
        pulse(3);
        rd_chk("R6 disarmed no capture", A_STAT, 32'h0);
        check("R6 disarmed wake", 32'(wake), 32'h0);
    endtask

    task automatic t_edge;
        wr(A_CTRL, 32'h3);
        @(negedge clk); irq_in[3] = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 not yet after two edges", 32'(wake), 32'h0);
        @(negedge clk);
        check("R6 pending after three edges", 32'(wake), 32'h1);
        irq_in[3] = 1'b0;
        repeat (3) @(negedge clk);
        rd_chk("R5 stat edge", A_STAT, 32'h8);
        wr(A_ACK, 32'hFFFF_FFFF);
        rd_chk("R4 ack all", A_STAT, 32'h0);
        check("R10 wake after ack", 32'(wake), 32'h0);
    endtask

    task automatic t_masked;
        pulse(0);
        rd_chk("R10 masked still latches", A_STAT, 32'h1);
        check("R10 masked no wake", 32'(wake), 32'h0);
        wr(A_ACK, 32'hFFFF_FFFF);
    endtask

    task automatic t_level;
        wr(A_CTRL, 32'h1);
        wr(A_SSET, 32'h4);
        rd_chk("R3 sens set level", A_SENS, 32'h4);
        @(negedge clk); irq_in[2] = 1'b1;
        repeat (4) @(negedge clk);
        rd_chk("R7 level pending", A_STAT, 32'h4);
        wr(A_ACK, 32'h4);
        repeat (2) @(negedge clk);
        rd_chk("R7 level relatch", A_STAT, 32'h4);
        wr(A_CTRL, 32'h3);
        wr(A_ACK, 32'h4);
        repeat (3) @(negedge clk);
        rd_chk("R8 edge-only overrides level", A_STAT, 32'h0);
        irq_in[2] = 1'b0;
        repeat (4) @(negedge clk);
        wr(A_SCLR, 32'h4);
        rd_chk("R2 sens clear", A_SENS, 32'h0);
    endtask

    task automatic t_polflip;
        wr(A_CTRL, 32'h2);
        wr(A_PCLR, 32'h2);
        repeat (2) @(negedge clk);
        wr(A_ACK, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h3);
        rd_chk("R9 quiet before flips", A_STAT, 32'h0);
        rd_chk("R3 pol bit1 negative", A_POL, 32'hFFFF_FFFD);
        wr(A_PSET, 32'h2);
        wr(A_PCLR, 32'h2);
        @(negedge clk);
        rd_chk("R9 flip capture", A_STAT, 32'h2);
        check("R9 flip wake", 32'(wake), 32'h1);
        wr(A_ACK, 32'h2);
    endtask

    task automatic t_upper;
        wr(A_MCLR + 8'd1, 32'h80);
        pulse(39);
        rd_chk("R1 upper word stat", A_STAT + 8'd1, 32'h80);
        rd_chk("R1 lower word untouched", A_STAT, 32'h0);
        check("R10 upper wake", 32'(wake), 32'h1);
        wr(A_ACK + 8'd1, 32'h80);
        rd_chk("R4 upper ack", A_STAT + 8'd1, 32'h0);
    endtask

    task automatic t_srst;
        pulse(3);
        wr(A_CTRL, 32'h7);
        @(negedge clk);
        rd_chk("R11 ctrl after soft reset", A_CTRL, 32'h2);
        rd_chk("R11 mask restored", A_MASK, 32'hFFFF_FFFF);
        rd_chk("R11 mask w1 restored", A_MASK + 8'd1, 32'h0000_00FF);
        rd_chk("R11 pending cleared", A_STAT, 32'h0);
        rd_chk("R11 pol kept", A_POL, 32'hFFFF_FFFD);
        check("R11 wake low", 32'(wake), 32'h0);
    endtask

    task automatic t_disarm;
        wr(A_CTRL, 32'h3);
        rd_chk("R12 armed ctrl", A_CTRL, 32'h3);
        wr(A_CTRL, 32'h2);
        rd_chk("R12 disarm keeps edge-only", A_CTRL, 32'h2);
    endtask

    task automatic t_unimpl;
        rd_chk("R12 ack window reads zero", A_ACK, 32'h0);
        rd_chk("R12 set window reads zero", A_MSET, 32'h0);
        rd_chk("R12 unused window", 8'd96, 32'h0);
        rd_chk("R12 word beyond lines", A_MASK + 8'd2, 32'h0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; irq_in = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_en = 1'b0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_windows();
        t_disabled();
        t_edge();
        t_masked();
        t_level();
        t_polflip();
        t_upper();
        t_srst();
        t_disarm();
        t_unimpl();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule